// File: doc/BRIEF.md
# Multi-Stream DMA Descriptor and Completion Register Bank

This block is the host-facing control front end for a bank of DMA streams. A 32-bit register bus is divided into equal windows, one per stream. Through its window the host queues buffer descriptors for the stream. A descriptor is a physical buffer address plus a byte count, and each half goes into its own command FIFO. The host also reads and retires completion words from a per-stream status FIFO. The data movement engine sits on the other side. It takes descriptors through a valid/ready handshake and pushes completion words back into the same status FIFO.

The host may also push its own words into the status FIFO. This lets it pre-load "buffer ready" entries before any transfer has run. Software treats bit 7 of a completion word as a success flag and bits 3:0 as the stream tag, and it is expected to check both. The block stores these words verbatim. Readback registers give a signature with a sticky overflow flag, the status FIFO head and occupancy, and the free space left in each command FIFO.

Top module: `dma_cs_regs`

## Requirements
- R1: The stream window is `busAddr[9:5]`, and the register inside it is `busAddr[4:2]`. An access is decoded only when `busAddr[1:0]==0` and the window index is below 16. Any other access reads zero and writes nothing. Register slots 1, 2 and 3 (byte offsets 4, 8, 12) read zero.
- R2: `busRdValid` is high in exactly the cycle after a cycle with `busRdEn` high. `busRdData` then holds the value the register had before that clock edge.
- R3: Reading byte offset 0 returns `{16'hACE0, 15'b0, ovf}`, where `ovf` is the stream's sticky overflow flag.
- R4: A write to offset 4 pushes an address and a write to offset 8 pushes a byte size, each into its own 32-entry FIFO. Offsets 24 and 28 read back 32 minus the respective occupancy. A write into a full command FIFO is ignored, even if the engine pops that FIFO in the same cycle.
- R5: `cmdValid[i]` is high exactly when both command FIFOs of stream i are non-empty. `cmdAddr`/`cmdSize` slice i shows the two head entries. Both FIFOs pop together in a cycle with `cmdValid[i] && cmdReady[i]`.
- R6: A write to offset 16 pushes the write data into the status FIFO. Reading offset 16 returns the head without removing it, or zero when the FIFO is empty. Offset 20 returns the occupancy.
- R7: Any write to offset 12 pops the status FIFO head. A pop while empty is ignored.
- R8: An engine push (`stsPush[i]`) and a host push on the same stream in the same cycle are both accepted when two slots are free, with the engine word placed ahead of the host word. With one free slot the engine word is kept and the host word is dropped.
- R9: Any status push that finds no free slot is dropped and sets the stream's overflow flag. Only a clear or a reset resets that flag.
- R10: A write to offset 0 with bit 0 set empties all three FIFOs of that stream and clears its overflow flag. In that cycle it overrides any handshake or push on the same stream. Other streams are unaffected. A write to offset 0 with bit 0 clear has no effect.
- R11: After reset every FIFO is empty, every overflow flag is clear, and `cmdValid` and `busRdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte address inside the register page |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| cmdValid | output | 16 | Per-stream descriptor available |
| cmdReady | input | 16 | Per-stream engine accepts descriptor |
| cmdAddr | output | 512 | Per-stream descriptor address, 32 bits each, stream i at [32i+31:32i] |
| cmdSize | output | 512 | Per-stream descriptor byte size, same packing |
| stsPush | input | 16 | Per-stream engine completion push |
| stsData | input | 512 | Per-stream completion word, same packing |

## Verification
The status FIFO of a stream can take an engine completion and a host status write in the same clock. The bench provokes this by driving `stsPush` and a host write to offset 16 on the same stream in the same cycle. It does so once with ample space and once with exactly one slot left. It judges the result by reading the head before and after a pop, by the occupancy, and by the overflow bit in the signature word. A clear landing together with an engine handshake and an engine push is provoked the same way. A queue-based model compares every output on every cycle through a long randomized phase in which such collisions recur.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

  localparam logic [15:0] SIG_TAG = 16'hACE0;

  // register slot inside a stream window (byte offset / 4)
  typedef enum logic [2:0] {
    REG_ID        = 3'd0,
    REG_CMD_ADDR  = 3'd1,
    REG_CMD_SIZE  = 3'd2,
    REG_STS_POP   = 3'd3,
    REG_STS       = 3'd4,
    REG_STS_OCC   = 3'd5,
    REG_ADDR_FREE = 3'd6,
    REG_SIZE_FREE = 3'd7
  } regIdx_t;

  typedef struct packed {
    logic    hit;
    logic    rd;
    logic    clr;
    logic    pushAddr;
    logic    pushSize;
    logic    popSts;
    logic    pushSts;
    regIdx_t idx;
  } regOp_t;

endpackage

// File: rtl/dma_cs_fifo.sv
module dma_cs_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  parameter bit DUAL  = 1'b0,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             pushA,
  input  logic [WIDTH-1:0] dataA,
  input  logic             pushB,
  input  logic [WIDTH-1:0] dataB,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wPtr, rPtr;
  logic accA, accB, doPop;

  always_comb begin
    accA  = pushA && (int'(count) < DEPTH);
    accB  = DUAL && pushB && ((int'(count) + int'(accA)) < DEPTH);
    doPop = pop && (count != '0);
  end

  assign head = mem[rPtr];

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (accA) mem[wPtr] <= dataA;
      if (accB) mem[wPtr + PW'(accA)] <= dataB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else begin
      wPtr  <= wPtr + PW'(accA) + PW'(accB);
      rPtr  <= rPtr + PW'(doPop);
      count <= count + CW'(accA) + CW'(accB) - CW'(doPop);
    end
  end

endmodule

// File: rtl/dma_cs_ctrl.sv
module dma_cs_ctrl
  import dma_cs_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int PAGE_BITS   = 10,
  parameter int WIN_BITS    = 5,
  localparam int SID_W = $clog2(NUM_STREAMS),
  localparam int SEL_W = PAGE_BITS - WIN_BITS
) (
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [PAGE_BITS-1:0] busAddr,
  input  logic                 wrBit0,
  output regOp_t               op,
  output logic [SID_W-1:0]     sel
);

  logic [SEL_W-1:0] winSel;
  logic aligned, wr;

  always_comb begin
    winSel  = busAddr[PAGE_BITS-1:WIN_BITS];
    aligned = (busAddr[1:0] == 2'b00);
    sel     = winSel[SID_W-1:0];

    op          = '0;
    op.hit      = aligned && (int'(winSel) < NUM_STREAMS);
    op.rd       = busRdEn;
    op.idx      = regIdx_t'(busAddr[WIN_BITS-1:2]);
    wr          = busWrEn && op.hit;
    op.clr      = wr && (op.idx == REG_ID) && wrBit0;
    op.pushAddr = wr && (op.idx == REG_CMD_ADDR);
    op.pushSize = wr && (op.idx == REG_CMD_SIZE);
    op.popSts   = wr && (op.idx == REG_STS_POP);
    op.pushSts  = wr && (op.idx == REG_STS);
  end

endmodule

// File: rtl/dma_cs_datapath.sv
module dma_cs_datapath
  import dma_cs_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 32,
  localparam int SID_W = $clog2(NUM_STREAMS),
  localparam int CW    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regOp_t                        op,
  input  logic [SID_W-1:0]              sel,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_STREAMS-1:0]        cmdReady,
  input  logic [NUM_STREAMS-1:0]        stsPush,
  input  logic [NUM_STREAMS*DATA_W-1:0] stsData,
  output logic [NUM_STREAMS-1:0]        cmdValid,
  output logic [NUM_STREAMS*DATA_W-1:0] cmdAddr,
  output logic [NUM_STREAMS*DATA_W-1:0] cmdSize,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid
);

  logic [CW-1:0]     aCnt [NUM_STREAMS];
  logic [CW-1:0]     sCnt [NUM_STREAMS];
  logic [CW-1:0]     tCnt [NUM_STREAMS];
  logic [DATA_W-1:0] tHead [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] ovf;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
    logic here, clrI, take, hostSts;
    logic [DATA_W-1:0] aHead, sHead, tRaw;
    logic dropEng, dropHost;

    assign here    = (sel == SID_W'(i));
    assign clrI    = op.clr && here;
    assign take    = cmdValid[i] && cmdReady[i];
    assign hostSts = op.pushSts && here;

    dma_cs_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .DUAL(1'b0)) u_addrQ (
      .clk(clk), .rstN(rstN), .clr(clrI),
      .pushA(op.pushAddr && here), .dataA(wrData),
      .pushB(1'b0), .dataB(wrData),
      .pop(take), .head(aHead), .count(aCnt[i]));

    dma_cs_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .DUAL(1'b0)) u_sizeQ (
      .clk(clk), .rstN(rstN), .clr(clrI),
      .pushA(op.pushSize && here), .dataA(wrData),
      .pushB(1'b0), .dataB(wrData),
      .pop(take), .head(sHead), .count(sCnt[i]));

    // engine completions take port A so they land ahead of host words
    dma_cs_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .DUAL(1'b1)) u_stsQ (
      .clk(clk), .rstN(rstN), .clr(clrI),
      .pushA(stsPush[i]), .dataA(stsData[i*DATA_W +: DATA_W]),
      .pushB(hostSts), .dataB(wrData),
      .pop(op.popSts && here), .head(tRaw), .count(tCnt[i]));

    assign cmdValid[i] = (aCnt[i] != '0) && (sCnt[i] != '0);
    assign cmdAddr[i*DATA_W +: DATA_W] = aHead;
    assign cmdSize[i*DATA_W +: DATA_W] = sHead;
    assign tHead[i] = (tCnt[i] == '0) ? '0 : tRaw;

    assign dropEng  = stsPush[i] && (int'(tCnt[i]) >= FIFO_DEPTH);
    assign dropHost = hostSts && ((int'(tCnt[i]) + int'(stsPush[i])) >= FIFO_DEPTH);

    always_ff @(posedge clk) begin
      if (!rstN || clrI) ovf[i] <= 1'b0;
      else if (dropEng || dropHost) ovf[i] <= 1'b1;
    end
  end

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    if (op.hit) begin
      case (op.idx)
        REG_ID:        rdNext = {SIG_TAG, {(DATA_W-17){1'b0}}, ovf[sel]};
        REG_STS:       rdNext = tHead[sel];
        REG_STS_OCC:   rdNext = DATA_W'(tCnt[sel]);
        REG_ADDR_FREE: rdNext = DATA_W'(FIFO_DEPTH) - DATA_W'(aCnt[sel]);
        REG_SIZE_FREE: rdNext = DATA_W'(FIFO_DEPTH) - DATA_W'(sCnt[sel]);
        default:       rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= op.rd;
      if (op.rd) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/dma_cs_regs.sv
module dma_cs_regs
  import dma_cs_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 32,
  parameter int PAGE_BITS   = 10,
  parameter int WIN_BITS    = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PAGE_BITS-1:0]          busAddr,
  input  logic                          busWrEn,
  input  logic [DATA_W-1:0]             busWrData,
  input  logic                          busRdEn,
  output logic [DATA_W-1:0]             busRdData,
  output logic                          busRdValid,
  output logic [NUM_STREAMS-1:0]        cmdValid,
  input  logic [NUM_STREAMS-1:0]        cmdReady,
  output logic [NUM_STREAMS*DATA_W-1:0] cmdAddr,
  output logic [NUM_STREAMS*DATA_W-1:0] cmdSize,
  input  logic [NUM_STREAMS-1:0]        stsPush,
  input  logic [NUM_STREAMS*DATA_W-1:0] stsData
);

  localparam int SID_W = $clog2(NUM_STREAMS);

  regOp_t op;
  logic [SID_W-1:0] sel;

  dma_cs_ctrl #(.NUM_STREAMS(NUM_STREAMS), .PAGE_BITS(PAGE_BITS), .WIN_BITS(WIN_BITS)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .wrBit0(busWrData[0]), .op(op), .sel(sel));

  dma_cs_datapath #(.NUM_STREAMS(NUM_STREAMS), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .op(op), .sel(sel), .wrData(busWrData),
    .cmdReady(cmdReady), .stsPush(stsPush), .stsData(stsData),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdSize(cmdSize),
    .rdData(busRdData), .rdValid(busRdValid));

endmodule

// File: rtl/dma_cs_checker.sv
module dma_cs_checker #(
  parameter int NUM_STREAMS = 16,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 32,
  parameter int PAGE_BITS   = 10,
  parameter int WIN_BITS    = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [PAGE_BITS-1:0]          busAddr,
  input logic                          busWrEn,
  input logic [DATA_W-1:0]             busWrData,
  input logic                          busRdEn,
  input logic [DATA_W-1:0]             busRdData,
  input logic                          busRdValid,
  input logic [NUM_STREAMS-1:0]        cmdValid,
  input logic [NUM_STREAMS-1:0]        cmdReady,
  input logic [NUM_STREAMS*DATA_W-1:0] cmdAddr
);

  logic inRange;
  logic [WIN_BITS-1:0] offs;
  assign inRange = (busAddr[1:0] == 2'b00) && (int'(busAddr[PAGE_BITS-1:WIN_BITS]) < NUM_STREAMS);
  assign offs    = busAddr[WIN_BITS-1:0];

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid); // R2
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid); // R2
  AST_SIG_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && inRange && offs == '0) |=> (busRdData[31:16] == 16'hACE0)); // R3
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && inRange && int'(offs) == 24) |=> (int'(busRdData) <= FIFO_DEPTH)); // R4
  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !inRange) |=> (busRdData == '0)); // R1

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_hold
    logic clrHere;
    assign clrHere = busWrEn && inRange && offs == '0 && busWrData[0] &&
                     (int'(busAddr[PAGE_BITS-1:WIN_BITS]) == i);
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (cmdValid[i] && !cmdReady[i] && !clrHere) |=>
        (cmdValid[i] && $stable(cmdAddr[i*DATA_W +: DATA_W]))); // R5
  end

endmodule

bind dma_cs_regs dma_cs_checker #(
  .NUM_STREAMS(NUM_STREAMS), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH),
  .PAGE_BITS(PAGE_BITS), .WIN_BITS(WIN_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .busRdValid(busRdValid), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdAddr(cmdAddr));

// File: tb/sim_dma_cs_regs.sv
module sim_dma_cs_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic [NS-1:0] cmdValid;
  logic [NS-1:0] cmdReady = '0;
  logic [NS*32-1:0] cmdAddr, cmdSize;
  logic [NS-1:0] stsPush = '0;
  logic [NS*32-1:0] stsData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cs_regs u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .busRdValid(busRdValid), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .stsPush(stsPush), .stsData(stsData));

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mA [NS][$];
  logic [31:0] mS [NS][$];
  logic [31:0] mT [NS][$];
  logic        mOvf [NS];
  logic        expRdValid = 1'b0;
  logic [31:0] expRd = '0;
  string       rdTag = "R2";

  function automatic logic [31:0] modelRead(logic [9:0] a);
    int s = int'(a[9:5]);
    int o = int'(a[4:2]);
    if (a[1:0] != 2'b00 || s >= NS) return '0;
    case (o)
      0: return {16'hACE0, 15'b0, mOvf[s]};
      4: return (mT[s].size() > 0) ? mT[s][0] : 32'h0;
      5: return 32'(mT[s].size());
      6: return 32'(DEPTH - mA[s].size());
      7: return 32'(DEPTH - mS[s].size());
      default: return '0;
    endcase
  endfunction

  function automatic string tagOf(logic [9:0] a);
    int o = int'(a[4:2]);
    if (a[1:0] != 2'b00 || int'(a[9:5]) >= NS) return "R1";
    case (o)
      0: return "R3";
      4, 5: return "R6";
      6, 7: return "R4";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) begin
        mA[i].delete(); mS[i].delete(); mT[i].delete(); mOvf[i] = 1'b0;
      end
      expRdValid = 1'b0;
    end else begin
      int s, o, preA, preS, preT, n;
      logic okw, here;
      expRdValid = busRdEn;
      if (busRdEn) begin
        expRd = modelRead(busAddr);
        rdTag = tagOf(busAddr);
      end
      s   = int'(busAddr[9:5]);
      o   = int'(busAddr[4:2]);
      okw = busWrEn && busAddr[1:0] == 2'b00 && s < NS;
      for (int i = 0; i < NS; i++) begin
        here = okw && (s == i);
        if (here && o == 0 && busWrData[0]) begin
          mA[i].delete(); mS[i].delete(); mT[i].delete(); mOvf[i] = 1'b0;
          continue;
        end
        preA = mA[i].size(); preS = mS[i].size(); preT = mT[i].size();
        if (preA > 0 && preS > 0 && cmdReady[i]) begin
          void'(mA[i].pop_front()); void'(mS[i].pop_front());
        end
        if (here && o == 1 && preA < DEPTH) mA[i].push_back(busWrData);
        if (here && o == 2 && preS < DEPTH) mS[i].push_back(busWrData);
        if (here && o == 3 && preT > 0) void'(mT[i].pop_front());
        n = preT;
        if (stsPush[i]) begin
          if (n < DEPTH) begin mT[i].push_back(stsData[i*32 +: 32]); n++; end
          else mOvf[i] = 1'b1;
        end
        if (here && o == 4) begin
          if (n < DEPTH) mT[i].push_back(busWrData);
          else mOvf[i] = 1'b1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk("R11", 32'(cmdValid), 32'h0);
      chk("R11", 32'(busRdValid), 32'h0);
    end else begin
      chk("R2", 32'(busRdValid), 32'(expRdValid));
      if (expRdValid) chk(rdTag, busRdData, expRd);
      for (int i = 0; i < NS; i++) begin
        logic v;
        v = (mA[i].size() > 0) && (mS[i].size() > 0);
        chk("R5", 32'(cmdValid[i]), 32'(v));
        if (v) begin
          chk("R5", cmdAddr[i*32 +: 32], mA[i][0]);
          chk("R5", cmdSize[i*32 +: 32], mS[i][0]);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int s, int off, logic [31:0] d);
    busAddr = 10'(s * 32 + off); busWrEn = 1'b1; busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic rdRaw(logic [9:0] a, output logic [31:0] v);
    busAddr = a; busRdEn = 1'b1;
    tick();
    busRdEn = 1'b0;
    v = busRdData;
  endtask

  task automatic rd(int s, int off, output logic [31:0] v);
    rdRaw(10'(s * 32 + off), v);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) tick();
    rstN = 1'b1;

    // reset state
    rd(0, 0, v);   chk("R3", v, 32'hACE00000);
    rd(0, 20, v);  chk("R11", v, 32'd0);
    rd(0, 24, v);  chk("R11", v, 32'd32);
    rd(15, 28, v); chk("R4", v, 32'd32);

    // descriptor needs both halves
    wr(3, 4, 32'h1000_0000);
    chk("R5", 32'(cmdValid[3]), 32'd0);
    wr(3, 8, 32'd2048);
    chk("R5", 32'(cmdValid[3]), 32'd1);
    chk("R5", cmdAddr[3*32 +: 32], 32'h1000_0000);
    rd(3, 24, v); chk("R4", v, 32'd31);
    cmdReady[3] = 1'b1; tick(); cmdReady[3] = 1'b0;
    chk("R5", 32'(cmdValid[3]), 32'd0);

    // command FIFO full: 33rd address ignored
    for (int k = 0; k < 33; k++) wr(2, 4, 32'(100 + k));
    rd(2, 24, v); chk("R4", v, 32'd0);
    for (int k = 0; k < 32; k++) wr(2, 8, 32'(k));
    cmdReady[2] = 1'b1;
    repeat (31) tick();
    chk("R4", cmdAddr[2*32 +: 32], 32'd131);
    tick();
    cmdReady[2] = 1'b0;
    chk("R4", 32'(cmdValid[2]), 32'd0);

    // status push, peek, pop
    wr(1, 16, 32'h81); wr(1, 16, 32'h82); wr(1, 16, 32'h83);
    rd(1, 16, v); chk("R6", v, 32'h81);
    rd(1, 16, v); chk("R6", v, 32'h81);
    rd(1, 20, v); chk("R6", v, 32'd3);
    wr(1, 12, 32'd1);
    rd(1, 16, v); chk("R7", v, 32'h82);
    wr(1, 12, 32'd0); wr(1, 12, 32'd0); wr(1, 12, 32'd0);
    rd(1, 20, v); chk("R7", v, 32'd0);
    rd(1, 16, v); chk("R6", v, 32'd0);
    wr(1, 16, 32'h8A);
    rd(1, 16, v); chk("R7", v, 32'h8A);

    // simultaneous engine and host status push
    stsPush[4] = 1'b1; stsData[4*32 +: 32] = 32'h84;
    wr(4, 16, 32'h94);
    stsPush[4] = 1'b0;
    rd(4, 20, v); chk("R8", v, 32'd2);
    rd(4, 16, v); chk("R8", v, 32'h84);
    wr(4, 12, 32'd1);
    rd(4, 16, v); chk("R8", v, 32'h94);
    wr(4, 12, 32'd1);

    // one free slot: engine kept, host dropped, overflow set
    for (int k = 0; k < 31; k++) wr(4, 16, 32'(k));
    stsPush[4] = 1'b1; stsData[4*32 +: 32] = 32'hE1;
    wr(4, 16, 32'hB1);
    stsPush[4] = 1'b0;
    rd(4, 20, v); chk("R8", v, 32'd32);
    rd(4, 0, v);  chk("R9", v, 32'hACE00001);
    wr(4, 12, 32'd1);
    wr(4, 16, 32'h77);
    wr(4, 16, 32'h78);
    rd(4, 20, v); chk("R9", v, 32'd32);
    rd(4, 0, v);  chk("R9", v, 32'hACE00001);

    // clear
    wr(5, 16, 32'h55);
    wr(4, 0, 32'd0);
    rd(4, 20, v); chk("R10", v, 32'd32);
    wr(4, 0, 32'd1);
    rd(4, 20, v); chk("R10", v, 32'd0);
    rd(4, 0, v);  chk("R10", v, 32'hACE00000);
    rd(5, 20, v); chk("R10", v, 32'd1);
    wr(6, 4, 32'hA6); wr(6, 8, 32'h16);
    cmdReady[6] = 1'b1; stsPush[6] = 1'b1; stsData[6*32 +: 32] = 32'hC6;
    wr(6, 0, 32'd1);
    cmdReady[6] = 1'b0; stsPush[6] = 1'b0;
    chk("R10", 32'(cmdValid[6]), 32'd0);
    rd(6, 20, v); chk("R10", v, 32'd0);
    rd(6, 24, v); chk("R10", v, 32'd32);

    // out-of-range, misaligned and write-only slots
    rdRaw(10'h200, v); chk("R1", v, 32'd0);
    busAddr = 10'h210; busWrEn = 1'b1; busWrData = 32'h99; tick(); busWrEn = 1'b0;
    rd(0, 20, v);  chk("R1", v, 32'd0);
    rdRaw(10'h001, v); chk("R1", v, 32'd0);
    busAddr = 10'h012; busWrEn = 1'b1; busWrData = 32'h98; tick(); busWrEn = 1'b0;
    rd(0, 20, v);  chk("R1", v, 32'd0);
    rd(5, 4, v);   chk("R1", v, 32'd0);

    // randomized phase with recurring collisions
    for (int c = 0; c < 3000; c++) begin
      int s, o;
      s = int'($urandom % 4) + 4;
      o = int'($urandom % 8);
      cmdReady = 16'($urandom);
      stsPush  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      for (int i = 0; i < NS; i++) stsData[i*32 +: 32] = $urandom;
      busAddr = 10'(s * 32 + o * 4);
      busRdEn = ($urandom % 2) == 0;
      busWrEn = ($urandom % 2) == 0;
      busWrData = (o == 0) ? 32'(($urandom % 20) == 0) : $urandom;
      tick();
    end
    busRdEn = 1'b0; busWrEn = 1'b0; cmdReady = '0; stsPush = '0;
    tick(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule